// File: doc/BRIEF.md
# Cascadable Parallel-to-Serial Shift Register

This block is a W-stage (default 8) shift register that either captures a parallel word or moves serial data one stage toward its last stage. Two interchangeable strobe pins, `cp_a` and `cp_b`, are OR-ed into an effective shift clock. One pin acts as the clock and the other as an active-low gate. An active-low load input has priority over everything else. The last stage is driven out in true and inverted form. Tying `ser_out` of one instance to `ser_in` of the next builds a longer converter.

All pins are treated as slow external signals. Each one passes through a two-flop synchronizer in the fast system clock domain. The parallel word is synchronized alongside the load pin so that the two stay aligned. Rising edges of the OR-ed strobe are found by comparing it with its registered previous value. A shift caused by `cp_b` rising while `cp_a` is low is reported on `odd_edge`. With `cp_b` in the gate role, that event is timing-sensitive usage.

Top module: `piso_shifter`

## Requirements
- R1: While the synchronized `load_n` is 0, stage n takes `par_in[n]` for every n, whatever the strobe and serial pins do. Stage W-1 is the one driven out.
- R2: A shift moves stage n to stage n+1 and puts `ser_in` into stage 0, so `ser_out` presents `par_in[W-1]` first and `par_in[0]` last.
- R3: A shift happens on each 0-to-1 change of (`cp_a` OR `cp_b`) while `load_n` is 1. Either pin may serve as the clock while the other is held at 0.
- R4: While either pin is held at 1, toggling the other pin causes no shift, and the register holds.
- R5: `ser_out_n` is always the exact complement of `ser_out`.
- R6: `odd_edge` pulses for one system cycle, together with the stage update, whenever an effective rising edge occurs while `cp_a` is 0. This applies whether or not a load is active.
- R7: A rising strobe edge while `load_n` is 0 is consumed without shifting. Releasing `load_n` while both pins are 0 causes no shift.
- R8: An input change is visible at the outputs after the third rising `clk` edge following it: two edges for synchronizing and one for the stage update.
- R9: Synchronous active-high `rst` clears all stages and `odd_edge`. It also arms the edge detector as if the strobe were high, so pins that are already high after reset produce no shift.
- R10: Two instances chained through `ser_out` to `ser_in`, sharing strobe and load pins, behave as one 2W-stage converter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, samples all pins |
| rst | input | 1 | Synchronous active-high reset |
| cp_a | input | 1 | Strobe pin A (clock role) |
| cp_b | input | 1 | Strobe pin B (gate role, interchangeable) |
| load_n | input | 1 | Active-low parallel load |
| ser_in | input | 1 | Serial data into stage 0 |
| par_in | input | W | Parallel word, bit n to stage n |
| ser_out | output | 1 | Last stage, true |
| ser_out_n | output | 1 | Last stage, inverted |
| odd_edge | output | 1 | Pulse: shift caused by B rising with A low |

## Verification
Only the last stage is visible, so a corrupted inner stage shows up at `ser_out` only after enough shifts to carry it to the end. That takes up to W-1 strobe edges, each of which costs at least three system cycles. A wrong edge-history bit shows up as an extra or missing shift on the very next strobe change, within three cycles. Comparing every cycle against a model, while shifting whole loaded words out, exposes both kinds of fault. The cascade test also exposes errors in the bit that crosses between instances.

// File: rtl/piso_pkg.sv
package piso_pkg;
    // Synchronized control pins, kept together through the synchronizer
    typedef struct packed {
        logic a;
        logic b;
        logic load_n;
        logic ser;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);
    // After reset: strobes high (no edge pending), load idle, serial low
    localparam ctl_t CTL_IDLE = '{a: 1'b1, b: 1'b1, load_n: 1'b1, ser: 1'b0};
endpackage

// File: rtl/piso_sync.sv
module piso_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain_q[i] <= RST_VAL;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/piso_edge.sv
module piso_edge (
    input  logic clk,
    input  logic rst,
    input  logic pin_a,
    input  logic pin_b,
    output logic fire,
    output logic odd_q
);
    typedef struct packed {
        logic eff_prev;
        logic odd;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic eff;

    always_comb begin
        eff       = pin_a | pin_b;
        fire      = eff & ~st_q.eff_prev;
        st_d      = st_q;
        st_d.eff_prev = eff;
        st_d.odd  = fire & ~pin_a;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.eff_prev <= 1'b1;
            st_q.odd      <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign odd_q = st_q.odd;
endmodule

// File: rtl/piso_stages.sv
module piso_stages #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_n,
    input  logic         shift,
    input  logic         ser,
    input  logic [W-1:0] par,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_d, stage_q;

    always_comb begin
        stage_d = stage_q;
        if (!load_n) begin
            stage_d = par;
        end else if (shift) begin
            stage_d = {stage_q[W-2:0], ser};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) stage_q <= '0;
        else     stage_q <= stage_d;
    end

    assign q = stage_q;
endmodule

// File: rtl/piso_shifter.sv
module piso_shifter #(
    parameter int W = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cp_a,
    input  logic         cp_b,
    input  logic         load_n,
    input  logic         ser_in,
    input  logic [W-1:0] par_in,
    output logic         ser_out,
    output logic         ser_out_n,
    output logic         odd_edge
);
    import piso_pkg::*;

    ctl_t         ctl_raw, ctl_s;
    logic [W-1:0] par_s;
    logic         s_a, s_b, s_load_n, s_ser;
    logic         shift_fire;
    logic [W-1:0] stage_q;

    assign ctl_raw = '{a: cp_a, b: cp_b, load_n: load_n, ser: ser_in};

    piso_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) ctl_sync_i (
        .clk(clk), .rst(rst), .din(ctl_raw), .dout(ctl_s)
    );

    piso_sync #(.W(W), .STAGES(SYNC_STAGES), .RST_VAL('0)) par_sync_i (
        .clk(clk), .rst(rst), .din(par_in), .dout(par_s)
    );

    assign s_a      = ctl_s.a;
    assign s_b      = ctl_s.b;
    assign s_load_n = ctl_s.load_n;
    assign s_ser    = ctl_s.ser;

    piso_edge edge_i (
        .clk(clk), .rst(rst), .pin_a(s_a), .pin_b(s_b),
        .fire(shift_fire), .odd_q(odd_edge)
    );

    piso_stages #(.W(W)) stages_i (
        .clk(clk), .rst(rst), .load_n(s_load_n), .shift(shift_fire),
        .ser(s_ser), .par(par_s), .q(stage_q)
    );

    assign ser_out   = stage_q[W-1];
    assign ser_out_n = ~stage_q[W-1];
endmodule

// File: rtl/piso_shifter_chk.sv
module piso_shifter_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         s_a,
    input logic         s_b,
    input logic         s_load_n,
    input logic         s_ser,
    input logic [W-1:0] par_s,
    input logic         shift_fire,
    input logic [W-1:0] stage_q,
    input logic         ser_out,
    input logic         ser_out_n,
    input logic         odd_edge
);
    assert_load_R1: assert property (@(posedge clk) disable iff (rst)
        !s_load_n |=> stage_q == $past(par_s));

    assert_shift_R2: assert property (@(posedge clk) disable iff (rst)
        (s_load_n && shift_fire) |=> stage_q == {$past(stage_q[W-2:0]), $past(s_ser)});

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (s_load_n && $past(s_a || s_b) && (s_a || s_b)) |=> $stable(stage_q));

    assert_compl_R5: assert property (@(posedge clk) disable iff (rst)
        ser_out_n == !ser_out);

    assert_odd_R6: assert property (@(posedge clk) disable iff (rst)
        odd_edge |-> ($past(s_b) && !$past(s_a)));

    assert_odd_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        odd_edge |=> !odd_edge);

    assert_reset_R9: assert property (@(posedge clk)
        rst |=> (stage_q == '0 && !odd_edge));
endmodule

bind piso_shifter piso_shifter_chk #(.W(W)) chk_i (
    .clk(clk), .rst(rst), .s_a(s_a), .s_b(s_b), .s_load_n(s_load_n),
    .s_ser(s_ser), .par_s(par_s), .shift_fire(shift_fire), .stage_q(stage_q),
    .ser_out(ser_out), .ser_out_n(ser_out_n), .odd_edge(odd_edge)
);

// File: tb/piso_shifter_tb_top.sv
`timescale 1ns/1ps
module piso_shifter_tb_top;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst;
    logic cp_a, cp_b, load_n, ser_in;
    logic [W-1:0] par1, par2;
    logic so1, so1_n, odd1, so2, so2_n, odd2;

    always #5 clk = ~clk;

    piso_shifter #(.W(W)) dut_i (
        .clk(clk), .rst(rst), .cp_a(cp_a), .cp_b(cp_b), .load_n(load_n),
        .ser_in(ser_in), .par_in(par1), .ser_out(so1), .ser_out_n(so1_n),
        .odd_edge(odd1)
    );

    // R10: second instance fed from the first one's true output
    piso_shifter #(.W(W)) dut2_i (
        .clk(clk), .rst(rst), .cp_a(cp_a), .cp_b(cp_b), .load_n(load_n),
        .ser_in(so1), .par_in(par2), .ser_out(so2), .ser_out_n(so2_n),
        .odd_edge(odd2)
    );

    typedef struct packed {
        logic [W-1:0] q;
        logic         prev;
        logic         flag;
        logic [3:0]   c1, c2;   // {a,b,load_n,ser}
        logic [W-1:0] p1, p2;
    } mdl_t;

    mdl_t m1, m2;
    int checks = 0, errors = 0;
    string cur_req = "R9";
    bit done = 0;

    function automatic mdl_t mdl_reset();
        mdl_t m;
        m.q = '0; m.prev = 1'b1; m.flag = 1'b0;
        m.c1 = 4'b1110; m.c2 = 4'b1110; m.p1 = '0; m.p2 = '0;
        return m;
    endfunction

    // One system clock edge per the requirements: two sync stages, then update
    function automatic mdl_t mdl_step(mdl_t m, logic [3:0] pins, logic [W-1:0] par);
        mdl_t n = m;
        logic eff, rise;
        eff  = m.c2[3] | m.c2[2];
        rise = eff & ~m.prev;
        n.flag = rise & ~m.c2[3];
        if (!m.c2[1])   n.q = m.p2;
        else if (rise)  n.q = {m.q[W-2:0], m.c2[0]};
        n.prev = eff;
        n.c2 = m.c1; n.p2 = m.p1;
        n.c1 = pins; n.p1 = par;
        return n;
    endfunction

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(logic a, logic b, logic ld, logic si, logic [W-1:0] pa, logic [W-1:0] pb);
        logic [3:0] pins2;
        cp_a = a; cp_b = b; load_n = ld; ser_in = si; par1 = pa; par2 = pb;
        @(posedge clk);
        pins2 = {a, b, ld, m1.q[W-1]};
        if (rst) begin
            m1 = mdl_reset(); m2 = mdl_reset();
        end else begin
            m2 = mdl_step(m2, pins2, pb);
            m1 = mdl_step(m1, {a, b, ld, si}, pa);
        end
        @(negedge clk);
        chk(cur_req, so1, m1.q[W-1]);
        chk("R5", so1_n, ~so1);
        chk("R5", so2_n, ~so2);
        chk("R6", odd1, m1.flag);
        chk("R10", so2, m2.q[W-1]);
    endtask

    task automatic hold(int n, logic a, logic b, logic ld, logic si, logic [W-1:0] pa, logic [W-1:0] pb);
        for (int i = 0; i < n; i++) tick(a, b, ld, si, pa, pb);
    endtask

    // Drive one effective strobe pulse on the chosen pin, other pin low
    task automatic pulse(bit use_b, logic si);
        hold(3, 1'b0, 1'b0, 1'b1, si, par1, par2);
        hold(3, !use_b, use_b, 1'b1, si, par1, par2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m1 = mdl_reset(); m2 = mdl_reset();
        rst = 1'b1;
        hold(3, 1'b1, 1'b1, 1'b1, 1'b0, '0, '0);
        rst = 1'b0;
        // R9: pins already high after reset must not shift
        cur_req = "R9";
        hold(4, 1'b1, 1'b1, 1'b1, 1'b1, '0, '0);
        chk("R9", odd1, 1'b0);

        // R1/R8: load then read out the whole word with pin A as clock
        cur_req = "R8";
        hold(4, 1'b0, 1'b1, 1'b0, 1'b0, 8'hA5, 8'h3C);
        cur_req = "R1";
        hold(3, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00);
        cur_req = "R2";
        for (int i = 0; i < 2 * W; i++) pulse(1'b0, i[0]);

        // R3: pin B as clock, A low (also flags R6)
        cur_req = "R3";
        hold(4, 1'b0, 1'b0, 1'b0, 1'b0, 8'h96, 8'hE1);
        for (int i = 0; i < 2 * W; i++) pulse(1'b1, i[1]);

        // R4: one pin held high, other toggles -> hold
        cur_req = "R4";
        hold(4, 1'b1, 1'b1, 1'b0, 1'b0, 8'hC3, 8'h5A);
        for (int i = 0; i < 6; i++) begin
            hold(3, 1'b1, 1'b0, 1'b1, 1'b1, '0, '0);
            hold(3, 1'b1, 1'b1, 1'b1, 1'b1, '0, '0);
            hold(3, 1'b0, 1'b1, 1'b1, 1'b1, '0, '0);
        end

        // R7: strobe rise during load, release with both pins low
        cur_req = "R7";
        hold(4, 1'b0, 1'b0, 1'b0, 1'b0, 8'h81, 8'h7E);
        hold(4, 1'b1, 1'b0, 1'b0, 1'b0, 8'h81, 8'h7E);
        hold(4, 1'b0, 1'b0, 1'b0, 1'b0, 8'h81, 8'h7E);
        hold(6, 1'b0, 1'b0, 1'b1, 1'b1, '0, '0);
        for (int i = 0; i < W; i++) pulse(1'b0, 1'b1);

        // Random mix
        cur_req = "R3";
        for (int k = 0; k < 3000; k++) begin
            logic a, b, ld, si;
            logic [W-1:0] pa, pb;
            a = 1'($urandom); b = 1'($urandom);
            ld = ($urandom % 8) != 0; si = 1'($urandom);
            pa = W'($urandom); pb = W'($urandom);
            hold(1 + int'($urandom % 4), a, b, ld, si, pa, pb);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule